// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

Two DMA channels share one internal address and data bus. This block decides which channel owns that bus for the next transfer. Each channel holds its request line high while it has work. The arbiter answers with a registered one-hot grant. A granted channel keeps the bus until it pulses its own done line. The arbiter then goes idle for one cycle and arbitrates again.

The ordering rule is set by one mode bit in channel 0's control register. A small register-write port updates that bit. In fixed mode the lower-numbered channel always wins a tie. In rotating mode the channel served most recently drops to the bottom of the order. The arbiter records the last channel served so that it can rotate. Reset selects rotating mode, with channel 1 recorded as the last served.

Top module: `dma_arb`

## Requirements
- R1: No more than one bit of `gnt_o` is ever high.
- R2: While no grant is held, if exactly one channel requests, the cycle after it sees that request `gnt_o` grants that channel. This holds in either mode and whatever channel was served last.
- R3: In fixed mode (mode bit = 1), when both channels request while no grant is held, the next cycle shows `gnt_o = 2'b01`.
- R4: In rotating mode (mode bit = 0), when both channels request while no grant is held, the channel not served most recently is granted on the next cycle. Each grant records its channel as the last served.
- R5: After reset `gnt_o` is `2'b00`, the mode is rotating and channel 1 counts as last served. The first tie is therefore granted to channel 0.
- R6: A grant stays unchanged until the granted channel's `done_i` bit is high at a clock edge. At that edge the grant clears, and at least one cycle with no grant follows before any new grant.
- R7: A write with `cfg_we_i = 1` and `cfg_addr_i = 0` loads bit 14 of `cfg_wdata_i` as the mode bit. The value 1 selects fixed mode and 0 selects rotating mode. The new mode is used for decisions from the next cycle on. A write made during a transfer leaves the current grant untouched.
- R8: A write to any address other than 0 does not change the mode. Bits of `cfg_wdata_i` other than bit 14 do not change the mode either.
- R9: While no grant is held and nothing is requested, `gnt_o` stays `2'b00` and the last-served record does not change.
- R10: A `done_i` bit from a channel that holds no grant has no effect. It neither releases a grant nor starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 2 | Per-channel transfer request, bit n for channel n |
| done_i | input | 2 | Per-channel end-of-transfer pulse |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_addr_i | input | 4 | Control register address (0 = channel 0 control) |
| cfg_wdata_i | input | 16 | Control register write data; bit 14 = mode |
| gnt_o | output | 2 | Registered one-hot bus grant |

## Verification
Every result of this block appears one clock edge after the inputs that cause it. A grant is visible one edge after the request is seen while idle. A release is visible one edge after done is seen. A mode write first affects the decision made in the cycle after the write. The bench drives each stimulus on the falling edge and queues the grant it expects right after the next rising edge. A monitor pops that value and compares it 1 ns after the rising edge. The ties that follow mode writes, releases and ignored writes or done pulses show the mode and the last-served state through the grant output.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int ARB_NUM_CH   = 2;
    localparam int ARB_ADDR_W   = 4;
    localparam int ARB_DATA_W   = 16;
    localparam int ARB_MODE_BIT = 14;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_FIXED  = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/dma_arb_mode_reg.sv
module dma_arb_mode_reg
    import dma_arb_pkg::*;
#(
    parameter int ADDR_W    = ARB_ADDR_W,
    parameter int DATA_W    = ARB_DATA_W,
    parameter int MODE_BIT  = ARB_MODE_BIT,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output arb_mode_e         mode_o
);
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

    arb_mode_e mode_d, mode_q;

    // only one bit of the write data matters to the arbiter
    wire unused_wdata = ^wdata_i;

    always_comb begin
        mode_d = mode_q;
        if (we_i && (addr_i == SEL)) begin
            mode_d = arb_mode_e'(wdata_i[MODE_BIT]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_q <= MODE_ROTATE;
        else         mode_q <= mode_d;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = ARB_NUM_CH,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] req_i,
    input  arb_mode_e         mode_i,
    input  logic [IDX_W-1:0]  last_i,
    output logic              valid_o,
    output logic [NUM_CH-1:0] pick_o,
    output logic [IDX_W-1:0]  idx_o
);
    always_comb begin
        int cand;
        valid_o = 1'b0;
        pick_o  = '0;
        idx_o   = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (mode_i == MODE_FIXED) begin
                cand = k;
            end else begin
                cand = int'(last_i) + 1 + k;
                if (cand >= NUM_CH) cand = cand - NUM_CH;
            end
            if (!valid_o && req_i[cand]) begin
                valid_o      = 1'b1;
                pick_o[cand] = 1'b1;
                idx_o        = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/dma_arb.sv
module dma_arb
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH    = ARB_NUM_CH,
    parameter int ADDR_W    = ARB_ADDR_W,
    parameter int DATA_W    = ARB_DATA_W,
    parameter int MODE_BIT  = ARB_MODE_BIT,
    localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] done_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [NUM_CH-1:0] gnt_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] gnt;
        logic [IDX_W-1:0]  last;
    } arb_state_t;

    localparam arb_state_t RESET_STATE = '{gnt: '0, last: IDX_W'(NUM_CH - 1)};

    arb_state_t st_d, st_q;
    arb_mode_e  mode_q;
    logic              pick_valid;
    logic [NUM_CH-1:0] pick_vec;
    logic [IDX_W-1:0]  pick_idx;
    logic [IDX_W-1:0]  last_q;

    dma_arb_mode_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MODE_BIT (MODE_BIT),
        .CTRL_ADDR(0)
    ) u_mode (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cfg_we_i),
        .addr_i (cfg_addr_i),
        .wdata_i(cfg_wdata_i),
        .mode_o (mode_q)
    );

    dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i  (req_i),
        .mode_i (mode_q),
        .last_i (st_q.last),
        .valid_o(pick_valid),
        .pick_o (pick_vec),
        .idx_o  (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.gnt != '0) begin
            if ((st_q.gnt & done_i) != '0) st_d.gnt = '0;
        end else if (pick_valid) begin
            st_d.gnt  = pick_vec;
            st_d.last = pick_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RESET_STATE;
        else         st_q <= st_d;
    end

    assign gnt_o  = st_q.gnt;
    assign last_q = st_q.last;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] req_i,
    input logic [1:0] done_i,
    input logic [1:0] gnt_o,
    input logic       mode_q,
    input logic [0:0] last_q
);
    wire idle = (gnt_o == 2'b00);

    assert_onehot_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    assert_lone_ch0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && req_i == 2'b01 |=> gnt_o == 2'b01);

    assert_lone_ch1_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && req_i == 2'b10 |=> gnt_o == 2'b10);

    assert_fixed_tie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && mode_q && req_i == 2'b11 |=> gnt_o == 2'b01);

    assert_rotate_after1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && !mode_q && req_i == 2'b11 && last_q == 1'b1 |=> gnt_o == 2'b01);

    assert_rotate_after0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && !mode_q && req_i == 2'b11 && last_q == 1'b0 |=> gnt_o == 2'b10);

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle && (gnt_o & done_i) == 2'b00 |=> $stable(gnt_o));

    assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o & done_i) != 2'b00 |=> gnt_o == 2'b00);

    assert_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle && req_i == 2'b00 |=> gnt_o == 2'b00 && $stable(last_q));
endmodule

bind dma_arb dma_arb_chk u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .done_i(done_i),
    .gnt_o (gnt_o),
    .mode_q(mode_q),
    .last_q(last_q)
);

// File: tb/sim_dma_arb.sv
`timescale 1ns/1ps
module sim_dma_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req = '0;
    logic [1:0]  done = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  gnt;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [1:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    // bench model state taken from the requirements
    logic [1:0] m_gnt;
    logic       m_last;
    logic       m_fixed;

    always #2 clk = ~clk;   // 250 MHz

    dma_arb u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .done_i(done),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .gnt_o(gnt)
    );

    task automatic step(input logic [1:0] r, input logic [1:0] d, input logic w,
                        input logic [3:0] a, input logic [15:0] wd, input string tag);
        item_t it;
        @(negedge clk);
        req = r; done = d; we = w; addr = a; wdata = wd;
        if (m_gnt != 2'b00) begin
            if ((m_gnt & d) != 2'b00) m_gnt = 2'b00;
        end else if (r == 2'b01 || r == 2'b10) begin
            m_gnt = r; m_last = r[1];
        end else if (r == 2'b11) begin
            if (m_fixed || m_last) begin m_gnt = 2'b01; m_last = 1'b0; end
            else                   begin m_gnt = 2'b10; m_last = 1'b1; end
        end
        if (w && a == 4'd0) m_fixed = wd[14];
        it.exp = m_gnt; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // monitor: compare each queued expectation just after the rising edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (gnt !== it.exp) begin
                    failures++;
                    $display("FAIL %s gnt actual=%b expected=%b", it.tag, gnt, it.exp);
                end
            end
        end
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        m_gnt = 2'b00; m_last = 1'b1; m_fixed = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (gnt !== 2'b00) begin
            failures++;
            $display("FAIL R5 reset gnt actual=%b expected=00", gnt);
        end
        rst_n = 1'b1;

        // R5: first tie after reset goes to channel 0
        step(2'b11, 2'b00, 0, 0, 0, "R5 first tie");
        step(2'b11, 2'b00, 0, 0, 0, "R6 hold");
        step(2'b11, 2'b01, 0, 0, 0, "R6 release");
        step(2'b11, 2'b00, 0, 0, 0, "R4 rotate to ch1");
        step(2'b11, 2'b10, 0, 0, 0, "R6 release ch1");
        step(2'b11, 2'b00, 0, 0, 0, "R4 rotate to ch0");
        step(2'b00, 2'b01, 0, 0, 0, "R6 release ch0");
        // R2: lone requester wins although it was served... ch0 last, request ch0
        step(2'b01, 2'b00, 0, 0, 0, "R2 lone ch0");
        step(2'b00, 2'b01, 0, 0, 0, "R6 release");
        // R7: switch to fixed mode
        step(2'b00, 2'b00, 1, 4'd0, 16'h4000, "R7 write fixed");
        step(2'b10, 2'b00, 0, 0, 0, "R2 lone ch1 fixed");
        step(2'b11, 2'b10, 0, 0, 0, "R6 release");
        step(2'b11, 2'b00, 0, 0, 0, "R3 fixed tie");
        step(2'b11, 2'b01, 0, 0, 0, "R6 release");
        step(2'b11, 2'b00, 0, 0, 0, "R3 fixed tie again");
        // R8: wrong address and other bits are ignored
        step(2'b00, 2'b01, 1, 4'd1, 16'h0000, "R8 write other addr");
        step(2'b11, 2'b00, 0, 0, 0, "R8 still fixed");
        step(2'b00, 2'b01, 1, 4'd0, 16'hFFFF, "R8 other bits set");
        step(2'b11, 2'b00, 0, 0, 0, "R8 still fixed after ffff");
        // R7: mode write during a transfer leaves grant alone
        step(2'b11, 2'b00, 1, 4'd0, 16'hBFFF, "R7 write rotate mid transfer");
        step(2'b11, 2'b00, 0, 0, 0, "R7 grant kept");
        // R10: done from the other channel ignored
        step(2'b11, 2'b10, 0, 0, 0, "R10 foreign done");
        step(2'b11, 2'b01, 0, 0, 0, "R6 release");
        step(2'b11, 2'b00, 0, 0, 0, "R4 rotating tie ch1");
        step(2'b00, 2'b10, 0, 0, 0, "R6 release");
        // R9: idle with no request, done pulses while idle do nothing
        step(2'b00, 2'b00, 0, 0, 0, "R9 idle");
        step(2'b00, 2'b11, 0, 0, 0, "R10 done while idle");
        step(2'b00, 2'b00, 0, 0, 0, "R9 idle again");
        step(2'b11, 2'b00, 0, 0, 0, "R9 last kept tie ch0");
        step(2'b00, 2'b01, 0, 0, 0, "R6 release");
        step(2'b00, 2'b00, 0, 0, 0, "R1 quiet");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule